// File: doc/BRIEF.md
# Byte-Masked Synchronous Single-Port SRAM

This block is a synthesizable single-port memory of 2^AW words, each DW bits wide, for use as an on-chip scratch store. Every access is taken on the rising clock edge. A low select input enables the macro for that cycle. The write strobe has one active-low bit for each byte of the word. Any low strobe bit makes the cycle a write to those bytes only. A strobe that is all ones makes the cycle a read.

Read data comes from an output register and appears after the edge that sampled the read. It then holds until the next read. The default policy for a write cycle leaves the output register untouched. A parameter can instead make a write cycle present the merged word. The storage is split into one byte-wide array per lane, and each lane is written by its own strobe bit. Memory contents are undefined until they are written.

Top module: `sync_sram`

## Requirements
- R1: While `rst_n` is low, and after release until the first read, `q_data` is all zeros.
- R2: A read cycle (`sel_n` low, `wr_n` all ones) samples `addr` at the rising edge, and the stored word appears on `q_data` right after that same edge.
- R3: A write cycle with every `wr_n` bit low stores the whole of `wdata` at `addr`.
- R4: Bit k of `wr_n` controls byte lane k, which is bits [8k+7:8k]. On a write, only lanes whose bit is low are updated, and the other lanes keep their old contents.
- R5: A read cycle leaves the memory contents unchanged, so repeated reads of one address return the same word.
- R6: With `sel_n` high, no lane is written, whatever `wr_n` is, and `q_data` keeps its value.
- R7: Under the default hold policy, `q_data` keeps its previous value during and after a write cycle until the next read.
- R8: Reads on consecutive cycles to different addresses, including address 0 and the top address, each deliver their own word one edge after being sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all accesses are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| sel_n | input | 1 | Active-low access select |
| wr_n | input | DW/8 | Active-low per-byte write strobe; all ones means read |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| q_data | output | DW | Registered read data |

## Verification
Each read result is due right after the rising edge that sampled the read. The bench drives inputs on the falling edge and samples `q_data` one time unit after the following rising edge, so it sees exactly the value from that one edge. A write shows no result on `q_data`; its effect is checked by a later read and compared against a bench-side shadow array that applies the same byte strobes. Hold behaviour for deselected cycles and write cycles is checked at the sample point of the cycle in question, against the value of the last read.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [0:0] {
    RDW_HOLD = 1'b0,
    RDW_NEW  = 1'b1
  } rdw_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int unsigned LANES = 4
) (
  input  logic             sel_n,
  input  logic [LANES-1:0] wr_n,
  output logic             rd_en,
  output logic             any_wr,
  output logic [LANES-1:0] lane_wr
);
  always_comb begin
    lane_wr = ~wr_n & {LANES{~sel_n}};
    any_wr  = |lane_wr;
    rd_en   = ~sel_n & (&wr_n);
  end
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int unsigned AW = 6
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [AW-1:0]                addr,
  input  logic [sram_pkg::LANE_W-1:0]  wbyte,
  output logic [sram_pkg::LANE_W-1:0]  rbyte
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [sram_pkg::LANE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[addr] <= wbyte;
    end
  end

  assign rbyte = store[addr];
endmodule

// File: rtl/sram_outreg.sv
module sram_outreg #(
  parameter int unsigned   DW  = 32,
  parameter sram_pkg::rdw_e RDW = sram_pkg::RDW_HOLD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          any_wr,
  input  logic [DW-1:0] arr_word,
  input  logic [DW-1:0] merged_word,
  output logic [DW-1:0] q
);
  logic          q_en;
  logic          wr_load;
  logic [DW-1:0] q_nxt;

  assign wr_load = any_wr & (RDW == sram_pkg::RDW_NEW);

  always_comb begin
    q_en  = rd_en | wr_load;
    q_nxt = rd_en ? arr_word : merged_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/sync_sram.sv
module sync_sram #(
  parameter int unsigned    AW  = 6,
  parameter int unsigned    DW  = 32,
  parameter sram_pkg::rdw_e RDW = sram_pkg::RDW_HOLD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_n,
  input  logic [DW/8-1:0]    wr_n,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      q_data
);
  localparam int unsigned LW    = sram_pkg::LANE_W;
  localparam int unsigned LANES = DW / LW;

  if (DW % LW != 0) begin : g_width_bad
    $error("sync_sram: DW must be a multiple of 8");
  end

  logic             rd_en;
  logic             any_wr;
  logic [LANES-1:0] lane_wr;
  logic [DW-1:0]    arr_word;
  logic [DW-1:0]    merged_word;

  sram_ctrl #(.LANES(LANES)) u_ctrl (
    .sel_n  (sel_n),
    .wr_n   (wr_n),
    .rd_en  (rd_en),
    .any_wr (any_wr),
    .lane_wr(lane_wr)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sram_lane #(.AW(AW)) u_lane (
      .clk  (clk),
      .wr_en(lane_wr[k]),
      .addr (addr),
      .wbyte(wdata[k*LW +: LW]),
      .rbyte(arr_word[k*LW +: LW])
    );
    assign merged_word[k*LW +: LW] = lane_wr[k] ? wdata[k*LW +: LW]
                                                : arr_word[k*LW +: LW];
  end

  sram_outreg #(.DW(DW), .RDW(RDW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .any_wr     (any_wr),
    .arr_word   (arr_word),
    .merged_word(merged_word),
    .q          (q_data)
  );
endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
  parameter int unsigned    AW  = 6,
  parameter int unsigned    DW  = 32,
  parameter sram_pkg::rdw_e RDW = sram_pkg::RDW_HOLD
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sel_n,
  input logic [DW/8-1:0] wr_n,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   q_data
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_zero_chk: assert (q_data == '0);
    end
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> $stable(q_data));

  // R7
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !(&wr_n) && RDW == sram_pkg::RDW_HOLD) |=> $stable(q_data));

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && (&wr_n) && $past(!sel_n && wr_n == '0) && addr == $past(addr))
      |=> q_data == $past(wdata, 2));
endmodule

bind sync_sram sram_chk #(.AW(AW), .DW(DW), .RDW(RDW)) u_chk (.*);

// File: tb/sync_sram_bench.sv
module sync_sram_bench;
  localparam int unsigned AW    = 6;
  localparam int unsigned DW    = 32;
  localparam int unsigned LN    = DW / 8;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          sel_n;
  logic [LN-1:0] wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] q_data;

  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] exp_q;
  int n_chk;
  int n_fail;

  sync_sram #(.AW(AW), .DW(DW)) u_sync_sram (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .q_data(q_data)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: q_data=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic [LN-1:0] w,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    sel_n = s; wr_n = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    if (!s) begin
      if (&w) exp_q = shadow[a];
      else for (int k = 0; k < int'(LN); k++)
        if (!w[k]) shadow[a][k*8 +: 8] = d[k*8 +: 8];
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; sel_n = 1'b1; wr_n = '1; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", q_data, '0);
    @(negedge clk) rst_n = 1'b1;
    cyc(1'b1, '1, '0, '0);
    check("R1 after release", q_data, '0);
    exp_q = '0;
  endtask

  task automatic t_full;
    cyc(1'b0, '0, 6'd5, 32'hA5A5_0001);
    cyc(1'b0, '1, 6'd5, '0);
    check("R2 R3 read addr5", q_data, 32'hA5A5_0001);
    cyc(1'b0, '0, 6'd6, 32'h0BAD_F00D);
    cyc(1'b0, '1, 6'd6, '0);
    check("R3 read addr6", q_data, 32'h0BAD_F00D);
  endtask

  task automatic t_mask;
    cyc(1'b0, '0, 6'd9, 32'h1122_3344);
    cyc(1'b0, 4'b1010, 6'd9, 32'hAABB_CCDD);
    cyc(1'b0, '1, 6'd9, '0);
    check("R4 lanes0,2", q_data, 32'h11BB_33DD);
    cyc(1'b0, 4'b0111, 6'd9, 32'hEE00_0000);
    cyc(1'b0, '1, 6'd9, '0);
    check("R4 lane3", q_data, 32'hEEBB_33DD);
  endtask

  task automatic t_read_only;
    cyc(1'b0, '1, 6'd9, 32'hFFFF_FFFF);
    check("R5 first read", q_data, shadow[9]);
    cyc(1'b0, '1, 6'd9, 32'h0000_0000);
    check("R5 second read", q_data, 32'hEEBB_33DD);
  endtask

  task automatic t_deselect;
    cyc(1'b0, '1, 6'd5, '0);
    check("R6 setup read", q_data, 32'hA5A5_0001);
    cyc(1'b1, '0, 6'd5, 32'hDEAD_BEEF);
    check("R6 deselected write holds q", q_data, 32'hA5A5_0001);
    cyc(1'b1, '1, 6'd6, '0);
    check("R6 deselected read holds q", q_data, 32'hA5A5_0001);
    cyc(1'b0, '1, 6'd5, '0);
    check("R6 contents unchanged", q_data, 32'hA5A5_0001);
  endtask

  task automatic t_write_hold;
    cyc(1'b0, '1, 6'd6, '0);
    check("R7 setup read", q_data, 32'h0BAD_F00D);
    cyc(1'b0, '0, 6'd6, 32'hC0DE_C0DE);
    check("R7 q held on write", q_data, 32'h0BAD_F00D);
    cyc(1'b0, 4'b1110, 6'd7, 32'h0000_0077);
    check("R7 q held on masked write", q_data, 32'h0BAD_F00D);
    cyc(1'b0, '1, 6'd6, '0);
    check("R7 new data after read", q_data, 32'hC0DE_C0DE);
  endtask

  task automatic t_stream;
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a;
      a = (i == 0) ? '0 : (i == 7) ? AW'(DEPTH - 1) : AW'(16 + i);
      cyc(1'b0, '0, a, 32'h5000_0000 + 32'(i * 32'h0101_0101));
    end
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a;
      a = (i == 0) ? '0 : (i == 7) ? AW'(DEPTH - 1) : AW'(16 + i);
      cyc(1'b0, '1, a, '0);
      check("R8 streamed read", q_data, 32'h5000_0000 + 32'(i * 32'h0101_0101));
      check("R8 shadow match", q_data, exp_q);
    end
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    t_reset();
    t_full();
    t_mask();
    t_read_only();
    t_deselect();
    t_write_hold();
    t_stream();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..R8 run: done=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule